// File: doc/BRIEF.md
# Substrate Egress Header Encapsulator

This block sits on the transmit side of a substrate line card. It takes one descriptor per outgoing meta frame and the meta frame's bytes. The descriptor carries the result of an earlier table lookup: a link-type code, the outgoing addresses, the VLAN tag control word, the metalink identifier, the meta frame length, the next-hop flag byte and next-hop address, and, for tunnels, the IPv4 endpoints. The block writes the outer header that matches the link type in front of the meta frame and sends the frame out one byte at a time. The descriptor input, the payload input and the output stream all use valid/ready handshakes. A byte moves only in a cycle where both valid and ready are high. A producer that raises valid keeps it and its data steady until ready is seen. While the output is stalled, the block holds out_valid, out_data and out_last. The payload input's ready is the output's ready, taken through in the payload phase.

Link types that need address resolution (multi-access and legacy IPv4) look up the next-hop address in a small fully associative cache. A configuration port writes that cache, and it is searched in the same cycle the descriptor is accepted. When no usable destination can be found, the frame is diverted. A diverted frame leaves as the bare meta frame, with no header and with out_exc high on every byte, so that the control processor can resolve the address. For every frame that is forwarded, the block flags with the last byte that the frame check sequence must be computed again downstream.

Top module: `subs_egress_encap`

## Requirements
- R1: A direct link (type code 0) gets a 22-byte header: destination MAC from the descriptor (6), source MAC (6), 0x8100 (2), TCI unchanged (2), the substrate EtherType parameter (default 0x88B5, 2), metalink ID (2) and meta frame length (2). The meta frame follows. Every multi-byte field is sent most significant byte first.
- R2: A VLAN0 link (type code 2) uses the R1 layout. The TCI's low 12 bits are replaced by the reserved VLAN0 identifier parameter (default 0x001), and the upper 4 bits are kept.
- R3: A tunnel link (type code 1) gets a 42-byte header: destination MAC, source MAC, 0x8100, TCI, 0x0800, then a 20-byte IPv4 header (0x45, 0x00, total length = 24 + meta length, identification 0, flags/offset 0, TTL parameter default 0x40, protocol parameter default 0xFD, checksum 0x0000, source address, destination address), then metalink ID and length.
- R4: A legacy IPv4 link (type code 4) gets an 18-byte header: destination MAC, source MAC, 0x8100, TCI, 0x0800, followed directly by the payload.
- R5: Multi-access (type code 3) and legacy links take the destination MAC from the cache entry whose key equals the next-hop address. Direct, VLAN0 and tunnel links always use the descriptor's destination MAC, even when a cache entry matches.
- R6: A diverted frame is output as the payload bytes only, with out_exc high on each byte.
- R7: Flag byte decoding: bits 7:6 are the next-hop type (00 none, 01 meta-network address, 10 MAC address) and bits 5:0 are the address length in bytes. A direct link is diverted unless the type is 00. A multi-access or legacy link is resolved only for type 01 with length 4, and otherwise is diverted. Type codes 5 to 7 are always diverted.
- R8: out_recrc is high exactly with the last byte of a forwarded frame, and never during a diverted frame.
- R9: Under output back-pressure no byte is lost, repeated or reordered, and the stalled output holds its value.
- R10: A configuration write replaces the whole cache entry. The next frame that looks up that entry uses the new MAC, and an entry written with its valid bit clear never matches.
- R11: After reset out_valid is low and desc_ready is high. desc_ready stays low from the accepted descriptor until the last byte of that frame has been handed over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Cache entry write strobe |
| cfg_idx | input | 3 | Cache entry index |
| cfg_valid | input | 1 | Valid bit written into the entry |
| cfg_key | input | 32 | Next-hop address key of the entry |
| cfg_mac | input | 48 | MAC address of the entry |
| desc_valid | input | 1 | Descriptor valid |
| desc_ready | output | 1 | Descriptor ready |
| desc_type | input | 3 | Link-type code |
| desc_flags | input | 8 | Next-hop flag byte |
| desc_nh | input | 32 | Next-hop address |
| desc_dmac | input | 48 | Configured destination MAC |
| desc_smac | input | 48 | Source MAC |
| desc_tci | input | 16 | VLAN tag control word |
| desc_mli | input | 16 | Metalink identifier |
| desc_len | input | 16 | Meta frame length field |
| desc_ip_src | input | 32 | Tunnel IPv4 source |
| desc_ip_dst | input | 32 | Tunnel IPv4 destination |
| pay_valid | input | 1 | Payload byte valid |
| pay_ready | output | 1 | Payload byte ready |
| pay_data | input | 8 | Payload byte |
| pay_last | input | 1 | Last payload byte of the frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte ready |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Last byte of the output frame |
| out_exc | output | 1 | Frame is diverted to the exception path |
| out_recrc | output | 1 | Frame check sequence must be recomputed |

## Verification
The hardest case to reach from the ports is a cache entry that matches a frame's next-hop key while the frame's link type forbids the cache. A second hard case is an entry rewritten or invalidated between two frames that use the same key. The stimulus programs entries whose keys equal the next-hop addresses of tunnel and direct frames. Between frames it rewrites one entry and clears another, then sends multi-access frames with those keys. A final run holds out_ready low at random points in mixed headers, payloads and diverted frames, so that stalls fall on the boundary between the last header byte and the first payload byte.

// File: rtl/enc_pkg.sv
package enc_pkg;

  typedef enum logic [2:0] {
    LT_DIRECT = 3'd0,
    LT_TUNNEL = 3'd1,
    LT_VLAN0  = 3'd2,
    LT_MULTI  = 3'd3,
    LT_LEGACY = 3'd4
  } link_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2
  } enc_state_t;

  localparam int HDR_MAX   = 42;
  localparam int HDR_IDX_W = $clog2(HDR_MAX + 1);

  localparam logic [1:0] NHT_NONE = 2'b00;
  localparam logic [1:0] NHT_MN   = 2'b01;

  typedef struct packed {
    link_t        ltype;
    logic [47:0]  smac;
    logic [15:0]  tci;
    logic [15:0]  mli;
    logic [15:0]  len;
    logic [31:0]  ip_src;
    logic [31:0]  ip_dst;
  } hdr_fields_t;

endpackage

// File: rtl/enc_arp_cache.sv
module enc_arp_cache #(
  parameter int DEPTH = 8,
  parameter int KEY_W = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic             wr_valid,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [47:0]      wr_mac,
  input  logic [KEY_W-1:0] lk_key,
  output logic             lk_hit,
  output logic [47:0]      lk_mac
);

  logic [DEPTH-1:0] match;
  logic [47:0]      mac_arr [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    logic             ent_v;
    logic [KEY_W-1:0] ent_key;
    logic [47:0]      ent_mac;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_v   <= 1'b0;
        ent_key <= '0;
        ent_mac <= '0;
      end else if (wr_en && wr_idx == IW'(gi)) begin
        ent_v   <= wr_valid;
        ent_key <= wr_key;
        ent_mac <= wr_mac;
      end
    end

    assign match[gi]   = ent_v && (ent_key == lk_key);
    assign mac_arr[gi] = ent_mac;
  end

  // lowest matching index wins
  always_comb begin
    lk_hit = 1'b0;
    lk_mac = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit = 1'b1;
        lk_mac = mac_arr[i];
      end
    end
  end

  // R10: a valid write is visible to a lookup of the same key in the next cycle
  a_r10_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_valid) |=> (lk_key != $past(wr_key) || lk_hit));

endmodule

// File: rtl/enc_route_decide.sv
module enc_route_decide
  import enc_pkg::*;
#(
  parameter int NH_BYTES = 4
) (
  input  link_t       ltype,
  input  logic [7:0]  flags,
  input  logic        arp_hit,
  output logic        use_arp,
  output logic        divert
);

  logic [1:0] nh_type;
  logic [5:0] nh_len;

  assign nh_type = flags[7:6];
  assign nh_len  = flags[5:0];

  always_comb begin
    use_arp = 1'b0;
    divert  = 1'b1;
    case (ltype)
      LT_DIRECT: divert = (nh_type != NHT_NONE);
      LT_TUNNEL,
      LT_VLAN0:  divert = 1'b0;
      LT_MULTI,
      LT_LEGACY: begin
        use_arp = 1'b1;
        divert  = !((nh_type == NHT_MN) && (nh_len == 6'(NH_BYTES)) && arp_hit);
      end
      default:   divert = 1'b1;
    endcase
  end

endmodule

// File: rtl/enc_hdr_builder.sv
module enc_hdr_builder
  import enc_pkg::*;
#(
  parameter logic [15:0] SUBS_ETYPE = 16'h88B5,
  parameter logic [7:0]  SUBS_PROTO = 8'hFD,
  parameter logic [7:0]  TUN_TTL    = 8'h40,
  parameter logic [11:0] VLAN0_ID   = 12'h001
) (
  input  hdr_fields_t            f,
  input  logic [47:0]            da,
  input  logic [HDR_IDX_W-1:0]   idx,
  output logic [7:0]             byte_o,
  output logic [HDR_IDX_W-1:0]   len_o
);

  localparam logic [15:0] ET_VLAN = 16'h8100;
  localparam logic [15:0] ET_IPV4 = 16'h0800;
  localparam logic [15:0] IP_FIXED = 16'd24;

  logic [HDR_MAX*8-1:0] hdr_vec;
  logic [15:0]          ip_total;
  logic [15:0]          tci_eff;

  assign ip_total = IP_FIXED + f.len;
  assign tci_eff  = (f.ltype == LT_VLAN0) ? {f.tci[15:12], VLAN0_ID} : f.tci;

  // headers are left-justified; byte 0 sits in the top eight bits
  always_comb begin
    case (f.ltype)
      LT_TUNNEL: begin
        hdr_vec = {da, f.smac, ET_VLAN, f.tci, ET_IPV4,
                   8'h45, 8'h00, ip_total, 16'h0000, 16'h0000,
                   TUN_TTL, SUBS_PROTO, 16'h0000, f.ip_src, f.ip_dst,
                   f.mli, f.len};
        len_o   = HDR_IDX_W'(42);
      end
      LT_LEGACY: begin
        hdr_vec = {da, f.smac, ET_VLAN, f.tci, ET_IPV4, 192'b0};
        len_o   = HDR_IDX_W'(18);
      end
      default: begin
        hdr_vec = {da, f.smac, ET_VLAN, tci_eff, SUBS_ETYPE, f.mli, f.len, 160'b0};
        len_o   = HDR_IDX_W'(22);
      end
    endcase
  end

  always_comb begin
    int sel;
    sel = HDR_MAX - 1 - int'(idx);
    if (sel >= 0) byte_o = hdr_vec[sel*8 +: 8];
    else          byte_o = 8'h00;
  end

endmodule

// File: rtl/subs_egress_encap.sv
module subs_egress_encap
  import enc_pkg::*;
#(
  parameter int          ARP_DEPTH  = 8,
  parameter int          NH_W       = 32,
  parameter logic [15:0] SUBS_ETYPE = 16'h88B5,
  parameter logic [7:0]  SUBS_PROTO = 8'hFD,
  parameter logic [7:0]  TUN_TTL    = 8'h40,
  parameter logic [11:0] VLAN0_ID   = 12'h001,
  localparam int         ARP_IW     = $clog2(ARP_DEPTH),
  localparam int         NH_BYTES   = NH_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ARP_IW-1:0] cfg_idx,
  input  logic              cfg_valid,
  input  logic [NH_W-1:0]   cfg_key,
  input  logic [47:0]       cfg_mac,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [2:0]        desc_type,
  input  logic [7:0]        desc_flags,
  input  logic [NH_W-1:0]   desc_nh,
  input  logic [47:0]       desc_dmac,
  input  logic [47:0]       desc_smac,
  input  logic [15:0]       desc_tci,
  input  logic [15:0]       desc_mli,
  input  logic [15:0]       desc_len,
  input  logic [31:0]       desc_ip_src,
  input  logic [31:0]       desc_ip_dst,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [7:0]        pay_data,
  input  logic              pay_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              out_exc,
  output logic              out_recrc
);

  enc_state_t             st_q;
  hdr_fields_t            hdr_q;
  hdr_fields_t            desc_in;
  logic [47:0]            da_q;
  logic                   exc_q;
  logic [HDR_IDX_W-1:0]   idx_q;
  logic [HDR_IDX_W-1:0]   hdr_len;
  logic [7:0]             hdr_byte;
  logic                   arp_hit;
  logic [47:0]            arp_mac;
  logic                   use_arp;
  logic                   divert;
  logic                   desc_fire;
  logic                   out_fire;

  assign desc_in = '{ltype:  link_t'(desc_type),
                     smac:   desc_smac,
                     tci:    desc_tci,
                     mli:    desc_mli,
                     len:    desc_len,
                     ip_src: desc_ip_src,
                     ip_dst: desc_ip_dst};

  enc_arp_cache #(.DEPTH(ARP_DEPTH), .KEY_W(NH_W)) u_arp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_idx),
    .wr_valid (cfg_valid),
    .wr_key   (cfg_key),
    .wr_mac   (cfg_mac),
    .lk_key   (desc_nh),
    .lk_hit   (arp_hit),
    .lk_mac   (arp_mac)
  );

  enc_route_decide #(.NH_BYTES(NH_BYTES)) u_decide (
    .ltype   (desc_in.ltype),
    .flags   (desc_flags),
    .arp_hit (arp_hit),
    .use_arp (use_arp),
    .divert  (divert)
  );

  enc_hdr_builder #(
    .SUBS_ETYPE (SUBS_ETYPE),
    .SUBS_PROTO (SUBS_PROTO),
    .TUN_TTL    (TUN_TTL),
    .VLAN0_ID   (VLAN0_ID)
  ) u_hdr (
    .f      (hdr_q),
    .da     (da_q),
    .idx    (idx_q),
    .byte_o (hdr_byte),
    .len_o  (hdr_len)
  );

  assign desc_ready = (st_q == ST_IDLE);
  assign desc_fire  = desc_valid && desc_ready;

  assign out_valid = (st_q == ST_HDR) || ((st_q == ST_PAY) && pay_valid);
  assign out_data  = (st_q == ST_HDR) ? hdr_byte : pay_data;
  assign out_last  = (st_q == ST_PAY) && pay_last;
  assign pay_ready = (st_q == ST_PAY) && out_ready;
  assign out_exc   = exc_q;
  assign out_recrc = out_last && !exc_q;
  assign out_fire  = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      hdr_q <= '0;
      da_q  <= '0;
      exc_q <= 1'b0;
      idx_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (desc_fire) begin
          hdr_q <= desc_in;
          da_q  <= use_arp ? arp_mac : desc_dmac;
          exc_q <= divert;
          idx_q <= '0;
          st_q  <= divert ? ST_PAY : ST_HDR;
        end
        ST_HDR: if (out_fire) begin
          if (idx_q == hdr_len - HDR_IDX_W'(1)) st_q <= ST_PAY;
          else                                 idx_q <= idx_q + HDR_IDX_W'(1);
        end
        ST_PAY: if (out_fire && pay_last) begin
          st_q  <= ST_IDLE;
          exc_q <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9: a stalled output keeps its byte
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R8: recompute flag only on the last byte of a forwarded frame
  a_r8_recrc_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_recrc |-> (out_last && !out_exc));

  // R11: no output while waiting for a descriptor
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    desc_ready |-> !out_valid);

  // R6: a diverted descriptor skips the header
  a_r6_divert_bare: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_fire && divert) |=> (out_exc && st_q == ST_PAY));

  // R5: types that must not consult the cache keep the descriptor address
  a_r5_no_cache: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_fire && (desc_type == 3'd0 || desc_type == 3'd1 || desc_type == 3'd2))
      |=> (da_q == $past(desc_dmac)));

endmodule

// File: tb/subs_egress_encap_tb.sv
module subs_egress_encap_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [2:0]  t;
    logic [7:0]  fl;
    logic [31:0] nh;
    logic [47:0] da;
    logic [47:0] sa;
    logic [15:0] tci;
    logic [15:0] mli;
    logic [15:0] len;
    logic [31:0] ips;
    logic [31:0] ipd;
  } bdesc_t;

  typedef struct {
    logic [7:0] d;
    bit         last;
    bit         exc;
    bit         recrc;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic cfg_valid = 1'b0;
  logic [31:0] cfg_key = '0;
  logic [47:0] cfg_mac = '0;
  logic desc_valid = 1'b0;
  logic desc_ready;
  logic [2:0] desc_type = '0;
  logic [7:0] desc_flags = '0;
  logic [31:0] desc_nh = '0;
  logic [47:0] desc_dmac = '0, desc_smac = '0;
  logic [15:0] desc_tci = '0, desc_mli = '0, desc_len = '0;
  logic [31:0] desc_ip_src = '0, desc_ip_dst = '0;
  logic pay_valid = 1'b0;
  logic pay_ready;
  logic [7:0] pay_data = '0;
  logic pay_last = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [7:0] out_data;
  logic out_last, out_exc, out_recrc;

  always #(CLK_PERIOD/2) clk = ~clk;

  subs_egress_encap u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_key(cfg_key), .cfg_mac(cfg_mac),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_type(desc_type), .desc_flags(desc_flags), .desc_nh(desc_nh),
    .desc_dmac(desc_dmac), .desc_smac(desc_smac), .desc_tci(desc_tci),
    .desc_mli(desc_mli), .desc_len(desc_len),
    .desc_ip_src(desc_ip_src), .desc_ip_dst(desc_ip_dst),
    .pay_valid(pay_valid), .pay_ready(pay_ready),
    .pay_data(pay_data), .pay_last(pay_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_exc(out_exc), .out_recrc(out_recrc)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit stall = 0;
  bit d_hs = 0, p_hs = 0, chk_busy = 0;

  bdesc_t     dq[$];
  logic [8:0] pq[$];
  exp_t       eq[$];

  bit          m_v[8];
  logic [31:0] m_key[8];
  logic [47:0] m_mac[8];

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic void put(logic [63:0] v, int n, string tag);
    for (int k = n - 1; k >= 0; k--) begin
      exp_t e;
      e.d = v[8*k +: 8]; e.last = 0; e.exc = 0; e.recrc = 0; e.tag = tag;
      eq.push_back(e);
    end
  endfunction

  function automatic void send_frame(bdesc_t d, int plen, logic [7:0] seed, string tag);
    bit div;
    bit hit;
    logic [47:0] da;
    da = d.da;
    hit = 0;
    for (int i = 0; i < 8; i++)
      if (!hit && m_v[i] && m_key[i] == d.nh) begin hit = 1; da = m_mac[i]; end
    if (d.t > 3'd4)                       div = 1;
    else if (d.t == 3'd0)                 div = (d.fl[7:6] != 2'b00);
    else if (d.t == 3'd3 || d.t == 3'd4)  div = !(d.fl[7:6] == 2'b01 && d.fl[5:0] == 6'd4 && hit);
    else begin                            div = 0; da = d.da; end
    if (d.t == 3'd0) da = d.da;
    dq.push_back(d);
    if (!div) begin
      put(64'(da), 6, tag);
      put(64'(d.sa), 6, tag);
      put(64'h8100, 2, tag);
      put(64'((d.t == 3'd2) ? {d.tci[15:12], 12'h001} : d.tci), 2, tag);
      if (d.t == 3'd4) begin
        put(64'h0800, 2, tag);
      end else if (d.t == 3'd1) begin
        put(64'h0800, 2, tag);
        put(64'h45, 1, tag); put(64'h00, 1, tag);
        put(64'(d.len + 16'd24), 2, tag);
        put(64'h0, 2, tag); put(64'h0, 2, tag);
        put(64'h40, 1, tag); put(64'hFD, 1, tag); put(64'h0, 2, tag);
        put(64'(d.ips), 4, tag); put(64'(d.ipd), 4, tag);
        put(64'(d.mli), 2, tag); put(64'(d.len), 2, tag);
      end else begin
        put(64'h88B5, 2, tag);
        put(64'(d.mli), 2, tag); put(64'(d.len), 2, tag);
      end
    end
    for (int i = 0; i < plen; i++) begin
      exp_t e;
      e.d = seed + 8'(i); e.last = (i == plen - 1); e.exc = div;
      e.recrc = e.last && !div; e.tag = tag;
      eq.push_back(e);
      pq.push_back({e.last, e.d});
    end
  endfunction

  function automatic bdesc_t mk(logic [2:0] t, logic [7:0] fl, logic [31:0] nh, logic [15:0] tci);
    bdesc_t d;
    d.t = t; d.fl = fl; d.nh = nh; d.tci = tci;
    d.da = 48'h0200_0000_00AA; d.sa = 48'h0200_0000_0055;
    d.mli = 16'h1234 + 16'(t); d.len = 16'd5;
    d.ips = 32'hC0A8_0001; d.ipd = 32'hC0A8_0002;
    return d;
  endfunction

  task automatic cfg_write(int idx, bit v, logic [31:0] key, logic [47:0] mac);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_valid = v; cfg_key = key; cfg_mac = mac;
    @(negedge clk);
    cfg_we = 0;
    m_v[idx] = v; m_key[idx] = key; m_mac[idx] = mac;
  endtask

  task automatic drain();
    wait (eq.size() == 0 && dq.size() == 0 && pq.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  // driver
  always @(negedge clk) begin
    if (d_hs) void'(dq.pop_front());
    if (p_hs) void'(pq.pop_front());
    d_hs = 0; p_hs = 0;
    desc_valid = (dq.size() > 0);
    if (dq.size() > 0) begin
      desc_type = dq[0].t; desc_flags = dq[0].fl; desc_nh = dq[0].nh;
      desc_dmac = dq[0].da; desc_smac = dq[0].sa; desc_tci = dq[0].tci;
      desc_mli = dq[0].mli; desc_len = dq[0].len;
      desc_ip_src = dq[0].ips; desc_ip_dst = dq[0].ipd;
    end
    pay_valid = (pq.size() > 0);
    if (pq.size() > 0) begin pay_data = pq[0][7:0]; pay_last = pq[0][8]; end
    out_ready = stall ? ($urandom % 3 != 0) : 1'b1;
  end

  // monitor, sampled one time unit before the rising edge
  always @(negedge clk) begin
    #(CLK_PERIOD/2 - 1);
    if (rst_n) begin
      if (chk_busy) chk(desc_ready == 1'b0, "R11", "desc_ready while busy", 64'(desc_ready), 64'h0);
      d_hs = desc_valid && desc_ready;
      p_hs = pay_valid && pay_ready;
      chk_busy = d_hs;
      if (out_valid && out_ready) begin
        if (eq.size() == 0) begin
          chk(0, "R9", "unexpected byte", 64'(out_data), 64'h0);
        end else begin
          exp_t e;
          e = eq.pop_front();
          chk(out_data == e.d, e.tag, "data", 64'(out_data), 64'(e.d));
          chk(out_last == e.last, e.tag, "last", 64'(out_last), 64'(e.last));
          chk(out_exc == e.exc, "R6", "exc", 64'(out_exc), 64'(e.exc));
          chk(out_recrc == e.recrc, "R8", "recrc", 64'(out_recrc), 64'(e.recrc));
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      chk(0, "R9", "watchdog expired", 64'(eq.size()), 64'h0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_key[i] = '0; m_mac[i] = '0; end
    repeat (3) @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R11", "reset out_valid", 64'(out_valid), 64'h0);
    chk(desc_ready == 1'b1, "R11", "reset desc_ready", 64'(desc_ready), 64'h1);
    @(negedge clk);
    rst_n = 1;
    #2;
    chk(out_valid == 1'b0 && desc_ready == 1'b1, "R11", "post-reset idle",
        64'({out_valid, desc_ready}), 64'h1);

    cfg_write(0, 1, 32'h0A00_0001, 48'h0211_2233_4401);
    cfg_write(1, 1, 32'h0A00_0002, 48'h0211_2233_4402);

    send_frame(mk(3'd0, 8'h00, 32'h0A00_0001, 16'h2064), 5, 8'h10, "R1");
    send_frame(mk(3'd2, 8'h00, 32'h0, 16'hA123), 4, 8'h20, "R2");
    send_frame(mk(3'd1, 8'h44, 32'h0A00_0001, 16'h3077), 6, 8'h30, "R3");
    send_frame(mk(3'd4, 8'h44, 32'h0A00_0002, 16'h0010), 3, 8'h40, "R4");
    send_frame(mk(3'd3, 8'h44, 32'h0A00_0001, 16'h0011), 5, 8'h50, "R5");
    send_frame(mk(3'd3, 8'h44, 32'h0A00_0009, 16'h0012), 4, 8'h60, "R6");
    send_frame(mk(3'd3, 8'h04, 32'h0A00_0001, 16'h0013), 2, 8'h70, "R7");
    send_frame(mk(3'd4, 8'h46, 32'h0A00_0002, 16'h0014), 2, 8'h78, "R7");
    send_frame(mk(3'd3, 8'h84, 32'h0A00_0002, 16'h0015), 2, 8'h7C, "R7");
    send_frame(mk(3'd0, 8'h44, 32'h0A00_0001, 16'h0016), 3, 8'h80, "R7");
    send_frame(mk(3'd6, 8'h00, 32'h0, 16'h0017), 1, 8'h88, "R7");
    send_frame(mk(3'd2, 8'h44, 32'h0A00_0002, 16'hF005), 1, 8'h90, "R5");
    drain();

    cfg_write(0, 1, 32'h0A00_0001, 48'h02AB_CDEF_0099);
    cfg_write(1, 0, 32'h0A00_0002, 48'h0211_2233_4402);
    send_frame(mk(3'd3, 8'h44, 32'h0A00_0001, 16'h0021), 3, 8'hA0, "R10");
    send_frame(mk(3'd4, 8'h44, 32'h0A00_0002, 16'h0022), 3, 8'hB0, "R10");
    drain();

    stall = 1;
    for (int r = 0; r < 5; r++) begin
      send_frame(mk(3'd1, 8'h00, 32'h0, 16'h0100 + 16'(r)), 3 + r, 8'(16 * r), "R9");
      send_frame(mk(3'd3, 8'h44, (r % 2 == 0) ? 32'h0A00_0001 : 32'h0A00_0007, 16'h0200), 2 + r, 8'hC0, "R9");
      send_frame(mk(3'd2, 8'h00, 32'h0, 16'h5FFF), 1, 8'hE0, "R9");
    end
    drain();
    stall = 0;

    chk(eq.size() == 0 && dq.size() == 0, "R9", "all frames delivered", 64'(eq.size()), 64'h0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule